// File: doc/BRIEF.md
# Interrupt Destination Match Arbiter

This block decides which processor agents in a cluster of up to sixteen take delivery of an inter-processor interrupt. A sender presents a destination byte, a physical-or-logical mode flag, a two-bit shorthand, a lowest-priority delivery flag and its own agent index. Each agent's 8-bit physical ID, 8-bit logical ID, logical model code and enable bit arrive as flat input vectors.

For ordinary delivery the block returns a bitmask with one bit per agent. For lowest-priority delivery it reduces the set of matching agents to at most one target. It picks that target with a rotating pointer, so the load spreads evenly across agents that are enabled. The result is registered and flagged valid in the cycle after the send strobe. Injecting the interrupt into the chosen agents is left to downstream logic.

Top module: `ipi_dest_arbiter`

## Requirements
- R1: With shorthand 0 and physical mode (`logical_i`=0), an agent is selected when `dest_i` is 8'hFF or equals that agent's physical ID.
- R2: With shorthand 0, logical mode, and an agent model code of 2'b00 (flat), the agent is selected when its logical ID AND `dest_i` is non-zero.
- R3: With shorthand 0, logical mode, and model code 2'b01 (cluster), the agent is selected when the upper nibbles of its logical ID and `dest_i` are equal and the lower nibbles AND to a non-zero value.
- R4: In logical mode, an agent whose model code is 2'b10 or 2'b11 is never selected through the destination field.
- R5: Shorthand 1 selects only the agent at `src_i`. Shorthand 2 selects every agent. Shorthand 3 selects every agent except the one at `src_i`. In all three cases `dest_i` and `logical_i` are ignored.
- R6: For lowest-priority delivery (`lowest_i`=1), the output has at most one bit set. The search begins at the index after the stored pointer, wraps at N_AGENTS, and skips agents that did not match or are disabled. The chosen index becomes the new pointer.
- R7: For lowest-priority delivery with no enabled matching agent, `mask_o` is zero and the pointer keeps its previous value.
- R8: `valid_o` is high in exactly the cycles that follow a cycle with `send_i` high. In every other cycle `mask_o` is zero.
- R9: Reset clears `mask_o` and `valid_o` and sets the pointer so that the first lowest-priority search starts at agent 0.
- R10: For ordinary delivery the enable bits have no effect: a disabled agent that matches is still set in `mask_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Send strobe; the request is evaluated in this cycle |
| dest_i | input | 8 | Destination byte |
| logical_i | input | 1 | 0 = physical destination mode, 1 = logical |
| shorthand_i | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| lowest_i | input | 1 | Lowest-priority delivery |
| src_i | input | IDX_W | Index of the sending agent |
| agent_id_i | input | 8*N_AGENTS | Physical ID of each agent, agent k at bits [8k+7:8k] |
| agent_lid_i | input | 8*N_AGENTS | Logical ID of each agent |
| agent_model_i | input | 2*N_AGENTS | Logical model code per agent (00 flat, 01 cluster) |
| agent_en_i | input | N_AGENTS | Agent enable bits |
| mask_o | output | N_AGENTS | Registered delivery mask |
| valid_o | output | 1 | Mask valid, one cycle after `send_i` |

## Verification
The bound checker watches properties that must hold on every cycle:
- the valid pulse tracks the send strobe;
- the mask is quiet when no send occurred;
- shorthand 1 and shorthand 3 produce exactly the expected pattern around the source agent;
- a lowest-priority result is one-hot or empty and never names a disabled agent.

Only the bench's scenarios can show the rest. These cover the address comparisons in physical, flat and cluster modes, the rejection of unknown model codes, and the exact rotation order of the pointer. They also show that the pointer is kept when no candidate exists and restored by reset, since that state is visible only through later results.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
    localparam int ID_W  = 8;
    localparam int NIB_W = ID_W / 2;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [1:0]      MODEL_FLAT    = 2'b00;
    localparam logic [1:0]      MODEL_CLUSTER = 2'b01;
    localparam logic [ID_W-1:0] DEST_ALL      = {ID_W{1'b1}};
endpackage

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
    import ipi_dest_pkg::*;
(
    input  logic [ID_W-1:0] dest_i,
    input  logic            logical_i,
    input  logic [1:0]      shorthand_i,
    input  logic            is_self_i,
    input  logic [ID_W-1:0] agent_id_i,
    input  logic [ID_W-1:0] agent_lid_i,
    input  logic [1:0]      agent_model_i,
    output logic            hit_o
);
    logic phys_hit;
    logic log_hit;

    always_comb begin
        phys_hit = (dest_i == DEST_ALL) || (dest_i == agent_id_i);

        case (agent_model_i)
            MODEL_FLAT:    log_hit = |(agent_lid_i & dest_i);
            MODEL_CLUSTER: log_hit = (agent_lid_i[ID_W-1:NIB_W] == dest_i[ID_W-1:NIB_W])
                                  && |(agent_lid_i[NIB_W-1:0] & dest_i[NIB_W-1:0]);
            default:       log_hit = 1'b0;
        endcase

        case (shorthand_e'(shorthand_i))
            SH_NONE:   hit_o = logical_i ? log_hit : phys_hit;
            SH_SELF:   hit_o = is_self_i;
            SH_ALL:    hit_o = 1'b1;
            SH_OTHERS: hit_o = !is_self_i;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipi_rr_picker.sv
module ipi_rr_picker #(
    parameter int N_AGENTS = 8,
    localparam int IDX_W   = $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] cand_i,
    input  logic [IDX_W-1:0]    ptr_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    pick_o,
    output logic [N_AGENTS-1:0] onehot_o
);
    int pos;

    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        pos     = 0;
        for (int k = 1; k <= N_AGENTS; k++) begin
            pos = (int'(ptr_i) + k) % N_AGENTS;
            if (!found_o && cand_i[pos]) begin
                found_o = 1'b1;
                pick_o  = IDX_W'(pos);
            end
        end
        onehot_o = '0;
        if (found_o) begin
            onehot_o[pick_o] = 1'b1;
        end
    end
endmodule

// File: rtl/ipi_dest_arbiter.sv
module ipi_dest_arbiter
    import ipi_dest_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDX_W   = $clog2(N_AGENTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     send_i,
    input  logic [ID_W-1:0]          dest_i,
    input  logic                     logical_i,
    input  logic [1:0]               shorthand_i,
    input  logic                     lowest_i,
    input  logic [IDX_W-1:0]         src_i,
    input  logic [ID_W*N_AGENTS-1:0] agent_id_i,
    input  logic [ID_W*N_AGENTS-1:0] agent_lid_i,
    input  logic [2*N_AGENTS-1:0]    agent_model_i,
    input  logic [N_AGENTS-1:0]      agent_en_i,
    output logic [N_AGENTS-1:0]      mask_o,
    output logic                     valid_o
);
    typedef struct packed {
        logic [N_AGENTS-1:0] mask;
        logic                valid;
        logic [IDX_W-1:0]    ptr;
    } arb_state_t;

    localparam logic [IDX_W-1:0] PTR_RESET = IDX_W'(N_AGENTS - 1);

    arb_state_t st_d, st_q;

    logic [N_AGENTS-1:0] hit;
    logic [N_AGENTS-1:0] cand;
    logic                rr_found;
    logic [IDX_W-1:0]    rr_pick;
    logic [N_AGENTS-1:0] rr_onehot;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        ipi_agent_match u_match (
            .dest_i        (dest_i),
            .logical_i     (logical_i),
            .shorthand_i   (shorthand_i),
            .is_self_i     (src_i == IDX_W'(g)),
            .agent_id_i    (agent_id_i[g*ID_W +: ID_W]),
            .agent_lid_i   (agent_lid_i[g*ID_W +: ID_W]),
            .agent_model_i (agent_model_i[g*2 +: 2]),
            .hit_o         (hit[g])
        );
    end

    assign cand = hit & agent_en_i;

    ipi_rr_picker #(.N_AGENTS(N_AGENTS)) u_picker (
        .cand_i   (cand),
        .ptr_i    (st_q.ptr),
        .found_o  (rr_found),
        .pick_o   (rr_pick),
        .onehot_o (rr_onehot)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = send_i;
        st_d.mask  = '0;
        if (send_i) begin
            if (lowest_i) begin
                if (rr_found) begin
                    st_d.mask = rr_onehot;
                    st_d.ptr  = rr_pick;
                end
            end else begin
                st_d.mask = hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '0;
            st_q.valid <= 1'b0;
            st_q.ptr   <= PTR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o  = st_q.mask;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/ipi_dest_arbiter_chk.sv
module ipi_dest_arbiter_chk #(
    parameter int N_AGENTS = 8,
    localparam int IDX_W   = $clog2(N_AGENTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                send_i,
    input logic [1:0]          shorthand_i,
    input logic                lowest_i,
    input logic [IDX_W-1:0]    src_i,
    input logic [N_AGENTS-1:0] agent_en_i,
    input logic [N_AGENTS-1:0] mask_o,
    input logic                valid_o
);
    localparam logic [N_AGENTS-1:0] ONE = {{(N_AGENTS-1){1'b0}}, 1'b1};

    // R8
    p_valid_follows_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
        send_i |=> valid_o);

    // R8
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !send_i |=> (!valid_o && mask_o == '0));

    // R5
    p_self_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !lowest_i && shorthand_i == 2'd1) |=> (mask_o == (ONE << $past(src_i))));

    // R5
    p_all_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && !lowest_i && shorthand_i == 2'd3) |=> (mask_o == ~(ONE << $past(src_i))));

    // R6
    p_lowest_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && lowest_i) |=> $onehot0(mask_o));

    // R6
    p_lowest_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_i && lowest_i) |=> ((mask_o & ~$past(agent_en_i)) == '0));
endmodule

bind ipi_dest_arbiter ipi_dest_arbiter_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .send_i      (send_i),
    .shorthand_i (shorthand_i),
    .lowest_i    (lowest_i),
    .src_i       (src_i),
    .agent_en_i  (agent_en_i),
    .mask_o      (mask_o),
    .valid_o     (valid_o)
);

// File: tb/ipi_dest_arbiter_bench.sv
module ipi_dest_arbiter_bench;
    localparam int N      = 8;
    localparam int IW     = $clog2(N);
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         send_i = 1'b0;
    logic [7:0]   dest_i = '0;
    logic         logical_i = 1'b0;
    logic [1:0]   shorthand_i = '0;
    logic         lowest_i = 1'b0;
    logic [IW-1:0] src_i = '0;
    logic [8*N-1:0] agent_id_i;
    logic [8*N-1:0] agent_lid_i;
    logic [2*N-1:0] agent_model_i;
    logic [N-1:0]   agent_en_i;
    logic [N-1:0]   mask_o;
    logic           valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ipi_dest_arbiter #(.N_AGENTS(N)) u_ipi_dest_arbiter (.*);

    // Agent setup: physical ID 0x20+k; agents 0..3 flat with logical IDs 01,02,04,08;
    // agents 4,5 cluster 0x31,0x32; agent 6 cluster 0x41; agent 7 unknown model code 2, logical ID 0xFF.
    // Agent 5 is disabled.
    initial begin
        for (int k = 0; k < N; k++) begin
            agent_id_i[k*8 +: 8] = 8'h20 + 8'(k);
            agent_model_i[k*2 +: 2] = 2'b00;
        end
        agent_lid_i[0*8 +: 8] = 8'h01;
        agent_lid_i[1*8 +: 8] = 8'h02;
        agent_lid_i[2*8 +: 8] = 8'h04;
        agent_lid_i[3*8 +: 8] = 8'h08;
        agent_lid_i[4*8 +: 8] = 8'h31;
        agent_lid_i[5*8 +: 8] = 8'h32;
        agent_lid_i[6*8 +: 8] = 8'h41;
        agent_lid_i[7*8 +: 8] = 8'hFF;
        agent_model_i[4*2 +: 2] = 2'b01;
        agent_model_i[5*2 +: 2] = 2'b01;
        agent_model_i[6*2 +: 2] = 2'b01;
        agent_model_i[7*2 +: 2] = 2'b10;
        agent_en_i = 8'b1101_1111;
    end

    // Row: {dest[7:0], logical, shorthand[1:0], src[2:0], expected mask[7:0]}
    localparam int NROWS = 11;
    localparam logic [21:0] ROWS [NROWS] = '{
        {8'h23, 1'b0, 2'd0, 3'd0, 8'h08}, // R1 ID equal
        {8'hFF, 1'b0, 2'd0, 3'd0, 8'hFF}, // R1 broadcast, R10 disabled agent 5 included
        {8'h99, 1'b0, 2'd0, 3'd0, 8'h00}, // R1 no match
        {8'h05, 1'b1, 2'd0, 3'd0, 8'h05}, // R2 flat
        {8'h33, 1'b1, 2'd0, 3'd0, 8'h33}, // R2 flat + R3 cluster, R10 agent 5
        {8'h42, 1'b1, 2'd0, 3'd0, 8'h02}, // R3 cluster low nibble miss
        {8'hFF, 1'b1, 2'd0, 3'd0, 8'h0F}, // R4 unknown model code never hits
        {8'h00, 1'b1, 2'd1, 3'd6, 8'h40}, // R5 self
        {8'h99, 1'b0, 2'd2, 3'd2, 8'hFF}, // R5 all
        {8'h23, 1'b0, 2'd3, 3'd7, 8'h7F}, // R5 all but self
        {8'h00, 1'b1, 2'd3, 3'd0, 8'hFE}  // R5 all but self
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, sample at the next falling edge.
    task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                        input logic [IW-1:0] s, input logic lo);
        dest_i = d; logical_i = lg; shorthand_i = sh; src_i = s; lowest_i = lo;
        send_i = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
    endtask

    task automatic lowest_all(input string tag, input logic [N-1:0] exp);
        send(8'h00, 1'b0, 2'd2, '0, 1'b1);
        check(tag, mask_o, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 mask at reset", mask_o, '0);
        check("R9 valid at reset", {7'b0, valid_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROWS; r++) begin
            send(ROWS[r][21:14], ROWS[r][13], ROWS[r][12:11], ROWS[r][10:8], 1'b0);
            check("R8 valid after send", {7'b0, valid_o}, 8'h01);
            check($sformatf("table row %0d", r), mask_o, ROWS[r][7:0]);
        end

        @(negedge clk);
        check("R8 valid idle", {7'b0, valid_o}, 8'h00);
        check("R8 mask idle", mask_o, '0);

        // R6 rotation from reset pointer, skipping disabled agent 5, wrapping at N
        lowest_all("R6 pick 0", 8'h01);
        lowest_all("R6 pick 1", 8'h02);
        lowest_all("R6 pick 2", 8'h04);
        lowest_all("R6 pick 3", 8'h08);
        lowest_all("R6 pick 4", 8'h10);
        lowest_all("R6 skip disabled 5", 8'h40);
        lowest_all("R6 pick 7", 8'h80);
        lowest_all("R6 wrap to 0", 8'h01);

        // R7 only candidate disabled: no target, pointer kept at 0
        send(8'h25, 1'b0, 2'd0, '0, 1'b1);
        check("R7 valid", {7'b0, valid_o}, 8'h01);
        check("R7 empty", mask_o, '0);
        lowest_all("R7 pointer kept", 8'h02);

        // R6 restricted candidate set (flat 0x05 -> agents 0, 2), pointer at 1
        send(8'h05, 1'b1, 2'd0, '0, 1'b1);
        check("R6 flat subset", mask_o, 8'h04);
        send(8'h05, 1'b1, 2'd0, '0, 1'b1);
        check("R6 flat subset wrap", mask_o, 8'h01);

        // R9 reset restores pointer
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mask in reset", mask_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        lowest_all("R9 search starts at 0", 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule